// File: doc/BRIEF.md
# Packed Vector Element Rotate Unit

This block decodes a 32-bit vector instruction word and rotates each lane of a 64-bit packed data word left or right. The lane width is chosen at run time from 8, 16, 32 or 64 bits, and lane 0 sits in the least significant bits. Each lane is an unsigned value that rotates on its own, and no bit moves from one lane into another. The rotate amount comes from one of three places: the matching lane of a second vector operand, a scalar register value applied to every lane, or a 6-bit immediate built from the instruction word.

The unit has one register stage. A caller presents the instruction, the operands, the old destination word and the per-lane mask bits together with `valid_in`. One clock later it reads the merged result, a write enable and an illegal-instruction flag. Lanes that the mask disables keep their old destination value. An instruction the unit does not recognise produces no write.

Top module: `vrot_unit`

## Requirements
- R1: An instruction with opcode bits [6:0] = 1010111 and funct6 bits [31:26] = 010101 is a rotate left. funct3 bits [14:12] = 000 selects the vector-vector form and 100 selects the vector-scalar form.
- R2: With the same opcode, funct6 = 010100 and funct3 = 000 or 100 is a rotate right, using the vector-vector or vector-scalar form respectively.
- R3: funct3 = 011 with funct6 = 010100 or 010101 is always a rotate right by an immediate. The immediate is {bit 26, bits 19:15}, which covers 0 to 63.
- R4: `sew_sel` 0, 1, 2 and 3 select lanes of 8, 16, 32 and 64 bits. Lane i occupies bits [i*W +: W] and is rotated with no bits crossing into another lane.
- R5: The rotate amount used is the supplied amount reduced to its low log2(W) bits. Any higher amount bits have no effect.
- R6: In the vector-vector form, lane i takes its amount from lane i of `vs1_data`. In the vector-scalar form, every lane takes its amount from `rs1_data`. The data operand is always `vs2_data`.
- R7: A rotate right by n gives the same lane result as a rotate left by (W - n) mod W. An effective amount of zero returns the lane unchanged.
- R8: When the mask-enable bit (bit 25) is 0, lane i is written only if `mask_bits[i]` is 1, and otherwise keeps lane i of `old_vd`. When bit 25 is 1, every lane is written.
- R9: Any other instruction word sets `illegal`, clears `vd_we`, and returns `old_vd` unchanged on `vd_data`.
- R10: The outputs are registered. `valid_out`, `vd_we`, `illegal` and `vd_data` reflect the input of the previous clock. Synchronous reset clears all four outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Input operands and instruction are valid |
| insn | input | 32 | Vector instruction word |
| sew_sel | input | 2 | Lane width select (8/16/32/64) |
| vs1_data | input | 64 | Per-lane rotate amounts for the vector-vector form |
| vs2_data | input | 64 | Data to rotate |
| rs1_data | input | 64 | Scalar rotate amount |
| old_vd | input | 64 | Previous destination value |
| mask_bits | input | 8 | Per-lane mask, bit i for lane i |
| valid_out | output | 1 | Result valid |
| vd_we | output | 1 | Destination write enable |
| illegal | output | 1 | Unrecognised instruction |
| vd_data | output | 64 | Merged destination word |

## Verification
The hardest case to reach is an immediate of 32 or more. Here bit 26 carries immediate bit 5 while the funct6 pattern reads as a rotate left, yet the operation must stay a rotate right. The bench sweeps all 64 immediate values at every lane width, and its encoder places immediate bit 5 in bit 26, so half of these words carry the rotate-left funct6 pattern. It also sweeps scalar amounts from 0 to 127 so that the amount bits above log2(W) are exercised. Finally, it pairs each right rotate with the matching left rotate and compares the two unit results.

// File: rtl/vrot_pkg.sv
package vrot_pkg;

  localparam logic [6:0] OPC_VEC = 7'b1010111;
  localparam logic [5:0] F6_ROL  = 6'b010101;
  localparam logic [5:0] F6_ROR  = 6'b010100;
  localparam logic [2:0] F3_VV   = 3'b000;
  localparam logic [2:0] F3_VX   = 3'b100;
  localparam logic [2:0] F3_VI   = 3'b011;

  localparam int NUM_SEW = 4;
  localparam int AMT_W   = 6;

  typedef enum logic [1:0] {
    SRC_VEC    = 2'd0,
    SRC_SCALAR = 2'd1,
    SRC_IMM    = 2'd2
  } amt_src_e;

  typedef struct packed {
    logic             legal;
    logic             rot_right;
    amt_src_e         src;
    logic             masked;
    logic [AMT_W-1:0] imm;
  } vrot_dec_t;

endpackage

// File: rtl/vrot_decode.sv
module vrot_decode
  import vrot_pkg::*;
(
  input  logic [31:0] insn,
  output vrot_dec_t   dec
);

  logic [5:0] f6;
  logic [2:0] f3;
  logic       opc_ok;
  logic       f6_ok;
  logic       unused_fields;

  assign f6     = insn[31:26];
  assign f3     = insn[14:12];
  assign opc_ok = (insn[6:0] == OPC_VEC);
  assign f6_ok  = (f6 == F6_ROL) || (f6 == F6_ROR);
  assign unused_fields = ^{insn[24:20], insn[11:7]};

  always_comb begin
    dec           = '0;
    dec.src       = SRC_VEC;
    dec.masked    = ~insn[25];
    dec.imm       = {insn[26], insn[19:15]};
    dec.rot_right = (f6 == F6_ROR);
    if (opc_ok && f6_ok) begin
      unique case (f3)
        F3_VV: begin
          dec.legal = 1'b1;
          dec.src   = SRC_VEC;
        end
        F3_VX: begin
          dec.legal = 1'b1;
          dec.src   = SRC_SCALAR;
        end
        F3_VI: begin
          dec.legal     = 1'b1;
          dec.src       = SRC_IMM;
          dec.rot_right = 1'b1;
        end
        default: dec.legal = 1'b0;
      endcase
    end
  end

  always_comb begin
    if (dec.legal) begin
      a_r9_legal_opcode: assert (insn[6:0] == OPC_VEC);
    end
    if (dec.legal && insn[14:12] == F3_VI) begin
      a_r3_imm_right: assert (dec.rot_right && dec.src == SRC_IMM);
    end
  end

endmodule

// File: rtl/vrot_lane.sv
module vrot_lane
  import vrot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]     din,
  input  logic [AMT_W-1:0] amt,
  input  logic             rot_right,
  output logic [W-1:0]     dout
);

  localparam int SH = $clog2(W);

  logic [SH-1:0]  n_eff;
  logic [SH-1:0]  left_amt;
  logic [2*W-1:0] dbl;
  logic           unused_amt;

  assign n_eff    = amt[SH-1:0];
  assign left_amt = rot_right ? (~n_eff + 1'b1) : n_eff;
  assign dbl      = {din, din} << left_amt;
  assign dout     = dbl[2*W-1:W];

  generate
    if (SH < AMT_W) begin : g_hi
      assign unused_amt = ^amt[AMT_W-1:SH];
    end else begin : g_nohi
      assign unused_amt = 1'b0;
    end
  endgenerate

  always_comb begin
    if (n_eff == '0) begin
      a_r7_zero_amount: assert (dout == din);
    end
  end

endmodule

// File: rtl/vrot_datapath.sv
module vrot_datapath
  import vrot_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [1:0]          sew_sel,
  input  vrot_dec_t           dec,
  input  logic [DATA_W-1:0]   vs1_data,
  input  logic [DATA_W-1:0]   vs2_data,
  input  logic [DATA_W-1:0]   rs1_data,
  input  logic [DATA_W-1:0]   old_vd,
  input  logic [DATA_W/8-1:0] mask_bits,
  output logic [DATA_W-1:0]   result
);

  logic [NUM_SEW-1:0][DATA_W-1:0] res_by_sew;
  logic unused_ops;

  assign unused_ops = ^{vs1_data, rs1_data[DATA_W-1:AMT_W], dec.legal};

  generate
    for (genvar g = 0; g < NUM_SEW; g++) begin : g_sew
      localparam int W = 8 << g;
      localparam int N = DATA_W / W;
      for (genvar i = 0; i < N; i++) begin : g_lane
        logic [AMT_W-1:0] lane_amt;
        logic [W-1:0]     rot;
        logic             active;

        always_comb begin
          unique case (dec.src)
            SRC_VEC:    lane_amt = vs1_data[i*W +: AMT_W];
            SRC_SCALAR: lane_amt = rs1_data[AMT_W-1:0];
            default:    lane_amt = dec.imm;
          endcase
        end

        vrot_lane #(.W(W)) u_lane (
          .din       (vs2_data[i*W +: W]),
          .amt       (lane_amt),
          .rot_right (dec.rot_right),
          .dout      (rot)
        );

        assign active = ~dec.masked | mask_bits[i];
        assign res_by_sew[g][i*W +: W] = active ? rot : old_vd[i*W +: W];
      end
    end
  endgenerate

  assign result = res_by_sew[sew_sel];

endmodule

// File: rtl/vrot_unit.sv
module vrot_unit
  import vrot_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_in,
  input  logic [31:0]         insn,
  input  logic [1:0]          sew_sel,
  input  logic [DATA_W-1:0]   vs1_data,
  input  logic [DATA_W-1:0]   vs2_data,
  input  logic [DATA_W-1:0]   rs1_data,
  input  logic [DATA_W-1:0]   old_vd,
  input  logic [DATA_W/8-1:0] mask_bits,
  output logic                valid_out,
  output logic                vd_we,
  output logic                illegal,
  output logic [DATA_W-1:0]   vd_data
);

  vrot_dec_t         dec;
  logic [DATA_W-1:0] dp_result;

  vrot_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  vrot_datapath #(.DATA_W(DATA_W)) u_dp (
    .sew_sel   (sew_sel),
    .dec       (dec),
    .vs1_data  (vs1_data),
    .vs2_data  (vs2_data),
    .rs1_data  (rs1_data),
    .old_vd    (old_vd),
    .mask_bits (mask_bits),
    .result    (dp_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      vd_we     <= 1'b0;
      illegal   <= 1'b0;
      vd_data   <= '0;
    end else begin
      valid_out <= valid_in;
      vd_we     <= valid_in & dec.legal;
      illegal   <= valid_in & ~dec.legal;
      if (valid_in) begin
        vd_data <= dec.legal ? dp_result : old_vd;
      end
    end
  end

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> (!valid_out && !vd_we && !illegal));
  a_r9_illegal_no_write: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!vd_we && valid_out));
  a_r9_illegal_holds_old: assert property (@(posedge clk) disable iff (rst)
    (valid_in && insn[6:0] != OPC_VEC) |=> (illegal && vd_data == $past(old_vd)));
  a_r8_all_masked_hold: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !insn[25] && mask_bits == '0) |=> (vd_data == $past(old_vd)));

endmodule

// File: tb/sim_vrot_unit.sv
`timescale 1ns/1ps
module sim_vrot_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_in;
  logic [31:0] insn;
  logic [1:0]  sew_sel;
  logic [63:0] vs1_data, vs2_data, rs1_data, old_vd;
  logic [7:0]  mask_bits;
  logic        valid_out, vd_we, illegal;
  logic [63:0] vd_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  vrot_unit u0 (
    .clk(clk), .rst(rst), .valid_in(valid_in), .insn(insn), .sew_sel(sew_sel),
    .vs1_data(vs1_data), .vs2_data(vs2_data), .rs1_data(rs1_data),
    .old_vd(old_vd), .mask_bits(mask_bits), .valid_out(valid_out),
    .vd_we(vd_we), .illegal(illegal), .vd_data(vd_data)
  );

  function automatic logic [31:0] mk(input logic [5:0] f6, input logic vm,
                                     input logic [4:0] f5, input logic [2:0] f3);
    return {f6, vm, 5'd2, f5, f3, 5'd1, 7'h57};
  endfunction

  function automatic logic [63:0] model(input logic [31:0] ins, input logic [1:0] sew,
      input logic [63:0] a1, input logic [63:0] d2, input logic [63:0] s,
      input logic [63:0] old, input logic [7:0] m, output logic lg);
    logic [5:0]  f6;
    logic [2:0]  f3;
    logic        right;
    logic [63:0] r;
    logic [63:0] amt;
    int w, n, srcb;
    f6 = ins[31:26];
    f3 = ins[14:12];
    lg = (ins[6:0] == 7'h57) && (f6 == 6'h15 || f6 == 6'h14) &&
         (f3 == 3'd0 || f3 == 3'd4 || f3 == 3'd3);
    right = (f3 == 3'd3) ? 1'b1 : (f6 == 6'h14);
    w = 8 << sew;
    r = old;
    for (int i = 0; i < 64 / w; i++) begin
      if (f3 == 3'd0) amt = a1 >> (i * w);
      else if (f3 == 3'd4) amt = s;
      else amt = {58'd0, ins[26], ins[19:15]};
      n = int'(amt & 64'(w - 1));
      if (ins[25] || m[i]) begin
        for (int j = 0; j < w; j++) begin
          srcb = right ? (j + n) % w : (j + w - n) % w;
          r[i*w + j] = d2[i*w + srcb];
        end
      end
    end
    return lg ? r : old;
  endfunction

  task automatic run(input logic [31:0] ins, input logic [1:0] sew, input logic [63:0] a1,
                     input logic [63:0] d2, input logic [63:0] s, input logic [63:0] old,
                     input logic [7:0] m, input string req);
    logic [63:0] exp_d;
    logic        lg;
    exp_d = model(ins, sew, a1, d2, s, old, m, lg);
    @(negedge clk);
    valid_in = 1'b1; insn = ins; sew_sel = sew; vs1_data = a1;
    vs2_data = d2; rs1_data = s; old_vd = old; mask_bits = m;
    @(negedge clk);
    valid_in = 1'b0;
    n_chk++;
    if (vd_data !== exp_d || vd_we !== lg || illegal !== !lg || valid_out !== 1'b1) begin
      n_fail++;
      $display("FAIL %s insn=%h sew=%0d: got d=%h we=%b ill=%b v=%b exp d=%h we=%b ill=%b v=1",
               req, ins, sew, vd_data, vd_we, illegal, valid_out, exp_d, lg, !lg);
    end
  endtask

  task automatic get(input logic [31:0] ins, input logic [1:0] sew, input logic [63:0] d2,
                     input logic [63:0] s, output logic [63:0] res);
    @(negedge clk);
    valid_in = 1'b1; insn = ins; sew_sel = sew; vs2_data = d2; rs1_data = s;
    mask_bits = 8'h00;
    @(negedge clk);
    valid_in = 1'b0;
    res = vd_data;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] ra, rb;
    rst = 1'b1; valid_in = 1'b0; insn = '0; sew_sel = '0; vs1_data = '0;
    vs2_data = '0; rs1_data = '0; old_vd = '0; mask_bits = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (valid_out !== 1'b0 || vd_we !== 1'b0 || illegal !== 1'b0 || vd_data !== 64'd0) begin
      n_fail++;
      $display("FAIL R10 reset: got v=%b we=%b ill=%b d=%h exp all zero",
               valid_out, vd_we, illegal, vd_data);
    end
    rst = 1'b0;

    for (int sw = 0; sw < 4; sw++) begin
      // R1 R5 R6: rotate left scalar over amounts 0..127
      for (int k = 0; k < 128; k++)
        run(mk(6'h15, 1'b1, 5'd0, 3'd4), 2'(sw), $urandom, {$urandom, $urandom},
            64'(k) | ({$urandom, 26'd0} << 7), 64'hdead_beef, 8'h00, "R1_R5_R6");
      // R2 R5: rotate right scalar
      for (int k = 0; k < 128; k++)
        run(mk(6'h14, 1'b1, 5'd0, 3'd4), 2'(sw), $urandom, {$urandom, $urandom},
            64'(k), 64'h0, 8'h00, "R2_R5");
      // R3: all immediates, bit 5 carried in bit 26
      for (int k = 0; k < 64; k++)
        run(mk(k[5] ? 6'h15 : 6'h14, 1'b1, k[4:0], 3'd3), 2'(sw), $urandom,
            {$urandom, $urandom}, 64'd0, 64'h0, 8'h00, "R3");
      // R4 R6: per-lane amounts, both directions
      for (int k = 0; k < 32; k++) begin
        run(mk(6'h15, 1'b1, 5'd3, 3'd0), 2'(sw), {$urandom, $urandom},
            {$urandom, $urandom}, 64'd0, 64'h0, 8'h00, "R4_R6");
        run(mk(6'h14, 1'b1, 5'd3, 3'd0), 2'(sw), {$urandom, $urandom},
            {$urandom, $urandom}, 64'd0, 64'h0, 8'h00, "R2_R6");
      end
      // R8: masked lanes keep old value
      for (int k = 0; k < 24; k++)
        run(mk(k[0] ? 6'h15 : 6'h14, 1'b0, 5'd7, k[1] ? 3'd4 : 3'd0), 2'(sw),
            {$urandom, $urandom}, {$urandom, $urandom}, 64'($urandom),
            {$urandom, $urandom}, 8'($urandom), "R8");
      run(mk(6'h15, 1'b0, 5'd7, 3'd4), 2'(sw), 64'd0, 64'h0123_4567_89ab_cdef,
          64'd3, 64'hffff_0000_ffff_0000, 8'h00, "R8");
    end

    // R7: right by n equals left by (W-n) mod W, compared on unit outputs
    for (int sw = 0; sw < 4; sw++) begin
      for (int k = 0; k < 64; k++) begin
        int w;
        logic [63:0] d;
        w = 8 << sw;
        d = {$urandom, $urandom};
        get(mk(6'h14, 1'b1, 5'd0, 3'd4), 2'(sw), d, 64'(k), ra);
        get(mk(6'h15, 1'b1, 5'd0, 3'd4), 2'(sw), d, 64'((w - (k % w)) % w), rb);
        n_chk++;
        if (ra !== rb) begin
          n_fail++;
          $display("FAIL R7 sew=%0d n=%0d: got %h exp %h", sw, k, ra, rb);
        end
      end
    end

    // R9: unrecognised encodings
    run(mk(6'h15, 1'b1, 5'd1, 3'd1), 2'd0, 64'd1, 64'h55, 64'd1, 64'hcafe, 8'hff, "R9");
    run(mk(6'h16, 1'b1, 5'd1, 3'd0), 2'd1, 64'd1, 64'h55, 64'd1, 64'hbeef, 8'hff, "R9");
    run(mk(6'h04, 1'b1, 5'd1, 3'd3), 2'd2, 64'd1, 64'h55, 64'd1, 64'h1234, 8'hff, "R9");
    run(mk(6'h14, 1'b1, 5'd1, 3'd7), 2'd3, 64'd1, 64'h55, 64'd1, 64'h9999, 8'hff, "R9");
    run(mk(6'h14, 1'b1, 5'd1, 3'd0) ^ 32'h1, 2'd0, 64'd1, 64'h55, 64'd1, 64'h7777, 8'hff, "R9");
    run(mk(6'h15, 1'b1, 5'd1, 3'd4) ^ 32'h40, 2'd3, 64'd1, 64'h55, 64'd1, 64'h4242, 8'hff, "R9");

    // R10: idle cycle drops valid_out and write enable
    @(negedge clk);
    n_chk++;
    if (valid_out !== 1'b0 || vd_we !== 1'b0 || illegal !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 idle: got v=%b we=%b ill=%b exp 0 0 0", valid_out, vd_we, illegal);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule